// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

The receiver watches a single serial line and rebuilds data words from it. The frame format comes from static configuration inputs: a word length from 5 to 8 bits, an optional parity bit, and one or two stop bits. Parity can be even, odd or stuck at a fixed level. Bit timing comes from a 16-bit divisor. The master clock divided by the divisor gives a tick at sixteen times the bit rate. The line passes through a two-flop synchronizer. A falling edge is confirmed half a bit later, and every later bit is sampled at its middle.

A finished word goes into a one-entry holding slot together with its parity, framing and break flags. The slot stays valid until the consumer pulses `rx_take`. If a further frame completes while the slot is still full, that new word is dropped and the overrun flag is raised on the held word. A frame in which every sampled bit is space counts as a line break, not as a framing error. After a break the receiver ignores the line until it returns to mark.

The control state machine has six states:
- `ST_HUNT` waits for a low sample on a tick.
- `ST_START` checks the start bit at its midpoint. It goes back to `ST_HUNT` if the line is high there, or on to `ST_DATA` if it is low.
- `ST_DATA` collects the data bits. It moves to `ST_PARITY` if parity is enabled, otherwise to `ST_STOP`.
- `ST_PARITY` takes one sample and moves to `ST_STOP`.
- `ST_STOP` samples one or two stop bits. It then goes to `ST_HUNT`, or to `ST_WAIT_MARK` after a break.
- `ST_WAIT_MARK` returns to `ST_HUNT` once the synchronized line is high.

Top module: `serial_rx_core`

## Requirements
- R1: After reset `rx_valid` and all flags are 0, and a line held at mark (1) delivers no word.
- R2: With 8 data bits and no parity, the start bit (0) is followed by data least-significant bit first and then the stop bit (1). `rx_data` carries only the data bits.
- R3: `len_sel` code 00 selects 5 data bits, 01 selects 6, 10 selects 7 and 11 selects 8. Data bits above the selected length read as 0.
- R4: With `par_en`=1, one parity bit follows the last data bit. `par_even`=1 expects an even count of ones over data and parity, and `par_even`=0 expects an odd count. A mismatch sets `rx_perr`, and `rx_perr` is never set when `par_en`=0.
- R5: With `par_en`=1 and `par_stick`=1 the parity bit is expected to be the inverse of `par_even`: 0 when `par_even`=1, 1 when `par_even`=0.
- R6: A stop bit sampled as 0 sets `rx_ferr`. With `stop_two`=1 both stop bits are sampled and either one being 0 sets `rx_ferr`.
- R7: A frame whose start, data, parity and stop samples are all 0 is delivered with `rx_brk`=1, `rx_ferr`=0 and `rx_data`=0. No further word is accepted until the line has returned to 1.
- R8: A low pulse shorter than half a bit period is rejected and delivers no word.
- R9: A word completing while the slot is full is discarded. The held word and its data stay unchanged and `rx_ovr` is set.
- R10: `rx_valid` rises after the middle of the last stop bit and before that stop bit ends. A one-cycle `rx_take` empties the slot and clears `rx_ovr`.
- R11: One bit lasts 16×`divisor` clock cycles, and a divisor of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Serial line, idle high |
| divisor | input | 16 | Clock cycles per oversample tick |
| len_sel | input | 2 | Word length code |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity when 1, odd when 0; stuck level select |
| par_stick | input | 1 | Parity bit stuck at a fixed level |
| stop_two | input | 1 | Two stop bits when 1 |
| rx_take | input | 1 | Consumer empties the holding slot |
| rx_valid | output | 1 | Holding slot full |
| rx_data | output | 8 | Received data, zero-extended |
| rx_perr | output | 1 | Parity error on held word |
| rx_ferr | output | 1 | Framing error on held word |
| rx_brk | output | 1 | Held word is a line break |
| rx_ovr | output | 1 | A later word was lost while this one was held |

## Verification
The result of a frame is due between the middle and the end of its last stop bit. That is 2 synchronizer cycles, plus up to one tick of detection phase, plus 8 ticks to the start midpoint and 16 ticks per later bit. The bench therefore reads `rx_valid` as 0 on the clock edge where the last stop bit begins, and reads the full result three cycles after that bit ends. The effect of `rx_take` is checked on the next falling edge after the one clock it is high. While a checked word is being held, a behavioural model compares `rx_valid` and `rx_data` on every clock until the take.

// File: rtl/rx_pkg.sv
package rx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_WAIT_MARK
    } rx_state_e;

    localparam int MIN_BITS = 5;

    // index of the final data bit for a length code
    function automatic logic [2:0] final_index(input logic [1:0] code);
        return 3'(MIN_BITS - 1) + {1'b0, code};
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_tick_gen.sv
module rx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] limit;

    assign limit = (divisor == '0) ? '0 : divisor - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= limit) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_parity_ref.sv
module rx_parity_ref #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_sel,
    input  logic              par_even,
    input  logic              par_stick,
    output logic              exp_bit
);
    localparam int MIN_BITS = rx_pkg::MIN_BITS;

    logic [DATA_W-1:0] keep;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign keep[i] = (i < MIN_BITS) ? 1'b1 : (i < MIN_BITS + int'(len_sel));
    end

    always_comb begin
        if (par_stick) exp_bit = ~par_even;
        else if (par_even) exp_bit = ^(data & keep);
        else exp_bit = ~^(data & keep);
    end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
    parameter int DIV_W       = 16,
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_in,
    input  logic [DIV_W-1:0] divisor,
    input  logic [1:0]       len_sel,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             par_stick,
    input  logic             stop_two,
    input  logic             rx_take,
    output logic             rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rx_brk,
    output logic             rx_ovr
);
    import rx_pkg::*;

    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    logic rx_s;
    logic tick;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(line_in), .q(rx_s)
    );

    rx_tick_gen #(.DIV_W(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    rx_state_e         state, state_n;
    logic [CNT_W-1:0]  tick_cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_bit;
    logic              stop_bad;
    logic              all_space;
    logic              stop_second;
    logic              exp_par;

    rx_parity_ref #(.DATA_W(DATA_W)) i_par (
        .data(shreg), .len_sel(len_sel), .par_even(par_even),
        .par_stick(par_stick), .exp_bit(exp_par)
    );

    logic start_mid, bit_mid, last_data, frame_done, brk_now, frm_now;

    assign start_mid  = tick && (tick_cnt == MID_CNT);
    assign bit_mid    = tick && (tick_cnt == LAST_CNT);
    assign last_data  = (bit_idx == IDX_W'(final_index(len_sel)));
    assign frame_done = (state == ST_STOP) && bit_mid && (!stop_two || stop_second);
    assign brk_now    = all_space && !rx_s;
    assign frm_now    = stop_bad || !rx_s;

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_HUNT:      if (tick && !rx_s) state_n = ST_START;
            ST_START:     if (start_mid) state_n = rx_s ? ST_HUNT : ST_DATA;
            ST_DATA:      if (bit_mid && last_data) state_n = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:    if (bit_mid) state_n = ST_STOP;
            ST_STOP:      if (frame_done) state_n = brk_now ? ST_WAIT_MARK : ST_HUNT;
            ST_WAIT_MARK: if (rx_s) state_n = ST_HUNT;
            default:      state_n = ST_HUNT;
        endcase
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_HUNT;
            tick_cnt    <= '0;
            bit_idx     <= '0;
            shreg       <= '0;
            par_bit     <= 1'b0;
            stop_bad    <= 1'b0;
            all_space   <= 1'b0;
            stop_second <= 1'b0;
        end else begin
            state <= state_n;
            if (tick) begin
                if (state == ST_HUNT || state == ST_WAIT_MARK) tick_cnt <= '0;
                else if (state == ST_START && start_mid)       tick_cnt <= '0;
                else                                           tick_cnt <= tick_cnt + 1'b1;
            end
            unique case (state)
                ST_START: if (start_mid) begin
                    bit_idx     <= '0;
                    shreg       <= '0;
                    par_bit     <= 1'b0;
                    stop_bad    <= 1'b0;
                    all_space   <= 1'b1;
                    stop_second <= 1'b0;
                end
                ST_DATA: if (bit_mid) begin
                    shreg[bit_idx] <= rx_s;
                    bit_idx        <= bit_idx + 1'b1;
                    all_space      <= all_space & ~rx_s;
                end
                ST_PARITY: if (bit_mid) begin
                    par_bit   <= rx_s;
                    all_space <= all_space & ~rx_s;
                end
                ST_STOP: if (bit_mid) begin
                    stop_second <= 1'b1;
                    stop_bad    <= stop_bad | ~rx_s;
                    all_space   <= all_space & ~rx_s;
                end
                default: ;
            endcase
        end
    end

    // holding slot outputs
    logic slot_free;
    assign slot_free = !rx_valid || rx_take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            rx_perr  <= 1'b0;
            rx_ferr  <= 1'b0;
            rx_brk   <= 1'b0;
            rx_ovr   <= 1'b0;
        end else begin
            if (rx_take) begin
                rx_valid <= 1'b0;
                rx_ovr   <= 1'b0;
            end
            if (frame_done) begin
                if (slot_free) begin
                    rx_valid <= 1'b1;
                    rx_data  <= shreg;
                    rx_perr  <= par_en && !brk_now && (par_bit != exp_par);
                    rx_ferr  <= !brk_now && frm_now;
                    rx_brk   <= brk_now;
                    rx_ovr   <= 1'b0;
                end else begin
                    rx_ovr <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        len_sel,
    input logic              par_en,
    input logic              rx_take,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_perr,
    input logic              rx_ferr,
    input logic              rx_brk,
    input logic              rx_ovr
);
    a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_take |=> rx_valid && $stable(rx_data));

    a_r9_ovr_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovr |-> rx_valid);

    a_r7_break_not_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_brk |-> !rx_ferr && rx_data == '0);

    a_r3_short_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) && $past(len_sel) == 2'b00 |-> rx_data[DATA_W-1:5] == '0);

    a_r4_no_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) && !$past(par_en) |-> !rx_perr);
endmodule

bind serial_rx_core rx_checker #(.DATA_W(DATA_W)) i_rx_checker (
    .clk(clk), .rst_n(rst_n), .len_sel(len_sel), .par_en(par_en),
    .rx_take(rx_take), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ovr(rx_ovr)
);

// File: tb/test_serial_rx_core.sv
module test_serial_rx_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_in = 1'b1;
    logic [15:0] divisor = 16'd2;
    logic [1:0]  len_sel = 2'b11;
    logic        par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0, stop_two = 1'b0;
    logic        rx_take = 1'b0;
    logic        rx_valid, rx_perr, rx_ferr, rx_brk, rx_ovr;
    logic [7:0]  rx_data;

    int n_checks = 0;
    int n_err = 0;
    int P = 32;
    bit m_hold = 0;
    logic [7:0] m_data = '0;
    bit finished = 0;

    always #5 clk = ~clk;

    serial_rx_core i_serial_rx_core (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .divisor(divisor),
        .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .stop_two(stop_two), .rx_take(rx_take),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ovr(rx_ovr)
    );

    task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // reference model: a held word must stay on the outputs every clock until taken
    always @(negedge clk) begin
        if (m_hold) begin
            n_checks++;
            if (rx_valid !== 1'b1 || rx_data !== m_data) begin
                n_err++;
                $display("FAIL R9 held word: actual=%0b/%0h expected=1/%0h", rx_valid, rx_data, m_data);
            end
        end
    end

    task automatic set_div(input int d);
        divisor = 16'(d);
        P = 16 * ((d == 0) ? 1 : d);
    endtask

    task automatic hold(input logic b, input int bits);
        line_in = b;
        repeat (bits * P) @(negedge clk);
    endtask

    task automatic send(input int n, input logic [7:0] d, input bit pen, input bit pb,
                        input bit s1, input bit two, input bit s2, input bit early, input string r);
        logic last;
        hold(1'b0, 1);
        for (int i = 0; i < n; i++) hold(d[i], 1);
        if (pen) hold(pb, 1);
        if (two) begin
            hold(s1, 1);
            last = s2;
        end else begin
            last = s1;
        end
        if (early) chk(r, "valid before last stop midpoint", rx_valid, 0);
        hold(last, 1);
        line_in = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_word(input string r, input logic [7:0] d, input bit pe,
                               input bit fe, input bit bk, input bit ov);
        chk(r, "valid", rx_valid, 1);
        chk(r, "data", rx_data, d);
        chk(r, "parity flag", rx_perr, pe);
        chk(r, "framing flag", rx_ferr, fe);
        chk(r, "break flag", rx_brk, bk);
        chk(r, "overrun flag", rx_ovr, ov);
        m_data = d;
        m_hold = 1;
    endtask

    task automatic take(input string r);
        m_hold = 0;
        rx_take = 1'b1;
        @(negedge clk);
        rx_take = 1'b0;
        chk(r, "valid after take", rx_valid, 0);
        chk(r, "overrun after take", rx_ovr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle mark
        chk("R1", "valid at reset", rx_valid, 0);
        chk("R1", "flags at reset", {rx_perr, rx_ferr, rx_brk, rx_ovr}, 0);
        hold(1'b1, 12);
        chk("R1", "no word on idle mark", rx_valid, 0);

        // R2 / R10: 8N1
        send(8, 8'hA5, 0, 0, 1, 0, 1, 1, "R10");
        expect_word("R2", 8'hA5, 0, 0, 0, 0);
        take("R10");

        // R3: word lengths
        len_sel = 2'b00;
        send(5, 8'hFF, 0, 0, 1, 0, 1, 1, "R3");
        expect_word("R3", 8'h1F, 0, 0, 0, 0);
        take("R3");
        len_sel = 2'b10;
        send(7, 8'h55, 0, 0, 1, 0, 1, 1, "R3");
        expect_word("R3", 8'h55, 0, 0, 0, 0);
        take("R3");

        // R4: even and odd parity
        len_sel = 2'b11; par_en = 1; par_even = 1;
        send(8, 8'h5A, 1, 0, 1, 0, 1, 1, "R4");
        expect_word("R4", 8'h5A, 0, 0, 0, 0);
        take("R4");
        send(8, 8'h5A, 1, 1, 1, 0, 1, 1, "R4");
        expect_word("R4", 8'h5A, 1, 0, 0, 0);
        take("R4");
        len_sel = 2'b10; par_even = 0;
        send(7, 8'h13, 1, 0, 1, 0, 1, 1, "R4");
        expect_word("R4", 8'h13, 0, 0, 0, 0);
        take("R4");
        send(7, 8'h13, 1, 1, 1, 0, 1, 1, "R4");
        expect_word("R4", 8'h13, 1, 0, 0, 0);
        take("R4");

        // R5: stuck parity
        len_sel = 2'b11; par_stick = 1; par_even = 1;
        send(8, 8'h01, 1, 0, 1, 0, 1, 1, "R5");
        expect_word("R5", 8'h01, 0, 0, 0, 0);
        take("R5");
        send(8, 8'h01, 1, 1, 1, 0, 1, 1, "R5");
        expect_word("R5", 8'h01, 1, 0, 0, 0);
        take("R5");
        par_even = 0;
        send(8, 8'h03, 1, 1, 1, 0, 1, 1, "R5");
        expect_word("R5", 8'h03, 0, 0, 0, 0);
        take("R5");
        par_stick = 0; par_en = 0;

        // R6: framing errors
        send(8, 8'h81, 0, 0, 0, 0, 0, 1, "R6");
        expect_word("R6", 8'h81, 0, 1, 0, 0);
        take("R6");
        hold(1'b1, 2);
        stop_two = 1;
        send(8, 8'h42, 0, 0, 1, 1, 0, 1, "R6");
        expect_word("R6", 8'h42, 0, 1, 0, 0);
        take("R6");
        hold(1'b1, 2);
        send(8, 8'h42, 0, 0, 1, 1, 1, 1, "R6");
        expect_word("R6", 8'h42, 0, 0, 0, 0);
        take("R6");
        stop_two = 0;

        // R7: break, then wait for mark
        hold(1'b0, 11);
        expect_word("R7", 8'h00, 0, 0, 1, 0);
        take("R7");
        hold(1'b0, 12);
        chk("R7", "no word while line stays space", rx_valid, 0);
        hold(1'b1, 2);
        send(8, 8'h3C, 0, 0, 1, 0, 1, 1, "R7");
        expect_word("R7", 8'h3C, 0, 0, 0, 0);
        take("R7");

        // R8: glitch rejection
        line_in = 1'b0;
        repeat (6) @(negedge clk);
        hold(1'b1, 3);
        chk("R8", "glitch gives no word", rx_valid, 0);

        // R9: overrun
        send(8, 8'h11, 0, 0, 1, 0, 1, 1, "R9");
        expect_word("R9", 8'h11, 0, 0, 0, 0);
        send(8, 8'h22, 0, 0, 1, 0, 1, 0, "R9");
        expect_word("R9", 8'h11, 0, 0, 0, 1);
        take("R9");

        // R11: divisor 0 acts as 1, divisor 3
        set_div(0);
        hold(1'b1, 2);
        send(8, 8'h96, 0, 0, 1, 0, 1, 1, "R11");
        expect_word("R11", 8'h96, 0, 0, 0, 0);
        take("R11");
        set_div(3);
        len_sel = 2'b01;
        hold(1'b1, 2);
        send(6, 8'h0F, 0, 0, 1, 0, 1, 1, "R11");
        expect_word("R11", 8'h0F, 0, 0, 0, 0);
        take("R11");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule